// File: doc/BRIEF.md
# Almost-Flag Offset Register Sequencer

This block holds the two distances that drive a FIFO's almost-empty and almost-full flag comparators. Each distance is a 16-bit register. Software or a controller reaches both of them over the FIFO's ordinary data buses, using one active-low load strobe together with the normal write and read enables. One clock serves both sides.

While the strobe is low, each write-enabled edge stores the low 16 data bits into the register the internal selector points at. Each read-enabled edge copies that register onto the output bus. Every such edge toggles the selector, so the accesses alternate: almost-empty distance first, then almost-full distance, then almost-empty again. A sequence may stop after one register. The selector keeps its position while the strobe is high, so the next loading session resumes at the other register. While the strobe is high, the enables pass through as plain FIFO read and write requests.

The selector is a two-state machine with states `SEL_EMPTY` and `SEL_FULL`. The access decoder sorts each cycle into one of five operations: `OP_PASS` (strobe high), `OP_HOLD` (strobe low, no enable), `OP_LOAD_WR`, `OP_LOAD_RD` and `OP_LOAD_BOTH`. The only transitions are `SEL_EMPTY -> SEL_FULL` and `SEL_FULL -> SEL_EMPTY`. Each is taken on an edge whose operation is `OP_LOAD_WR`, `OP_LOAD_RD` or `OP_LOAD_BOTH`. Under any other operation the state stays put.

Top module: `almost_ofs_seq`

## Requirements
- R1: After reset both distances read 127, the selector points at the almost-empty register, and the output bus is all zeros.
- R2: An edge with `load_n` = 0 and `wr_en_n` = 0 stores `din[15:0]` into the selected register. Upper data bits are dropped, and the other register is unchanged.
- R3: Qualified accesses alternate between the registers: the first goes to almost-empty, the second to almost-full, the third to almost-empty again, and so on.
- R4: An edge with `load_n` = 0 and both enables high changes neither register, the selector nor the output bus.
- R5: While `load_n` = 1, `fifo_wr_req` equals the inverse of `wr_en_n` and `fifo_rd_req` equals the inverse of `rd_en_n`, and neither register nor the selector changes. While `load_n` = 0, both requests are 0.
- R6: The selector keeps its position across periods with `load_n` high, so a later session continues with the other register.
- R7: An edge with `load_n` = 0 and `rd_en_n` = 0 places the selected register on `dout[15:0]` with `dout[17:16]` = 0, visible after that edge, and advances the selector.
- R8: `dout` holds its value on every edge that is not a read-back edge.
- R9: When write and read are both enabled under load on the same edge, `dout` shows the register's prior value, the register takes the new data, and the selector advances exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Active-low offset access strobe |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| din | input | 18 | Data bus; bits 15:0 carry a distance |
| dout | output | 18 | Read-back bus |
| ae_ofs | output | 16 | Almost-empty distance to comparator |
| af_ofs | output | 16 | Almost-full distance to comparator |
| fifo_wr_req | output | 1 | Normal FIFO write request |
| fifo_rd_req | output | 1 | Normal FIFO read request |

## Verification
Directed sequences cover the pure write run (empty, full, empty) and the pure read-back run. They also cover a single write followed by a strobe-high gap, which shows whether the selector really persists rather than restarting. Enable-free strobe cycles and writes with the upper data bits set separate a true no-operation from a silent store, and they show whether bits 17:16 are truncated. Simultaneous write and read under load tells a read of the old contents from a read of the new ones, and shows whether the selector takes one step or two. Random cycles with the strobe biased low then mix all five operations against a reference model, so interleavings that no directed case reaches also get compared.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    typedef enum logic [2:0] {
        OP_PASS      = 3'd0,
        OP_HOLD      = 3'd1,
        OP_LOAD_WR   = 3'd2,
        OP_LOAD_RD   = 3'd3,
        OP_LOAD_BOTH = 3'd4
    } ofs_op_e;

    localparam int unsigned NUM_OFS = 2;

endpackage

// File: rtl/ofs_op_decode.sv
module ofs_op_decode
    import ofs_seq_pkg::*;
(
    input  logic    load_n,
    input  logic    wr_en_n,
    input  logic    rd_en_n,
    output ofs_op_e op,
    output logic    fifo_wr_req,
    output logic    fifo_rd_req
);

    always_comb begin
        if (load_n) begin
            op = OP_PASS;
        end else begin
            unique case ({wr_en_n, rd_en_n})
                2'b00:   op = OP_LOAD_BOTH;
                2'b01:   op = OP_LOAD_WR;
                2'b10:   op = OP_LOAD_RD;
                default: op = OP_HOLD;
            endcase
        end
    end

    always_comb begin
        fifo_wr_req = (op == OP_PASS) && !wr_en_n;
        fifo_rd_req = (op == OP_PASS) && !rd_en_n;
    end

endmodule

// File: rtl/ofs_sel_fsm.sv
module ofs_sel_fsm
    import ofs_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ofs_op_e  op,
    output ofs_sel_e sel,
    output logic     wr_hit,
    output logic     rd_hit
);

    ofs_sel_e state_q, state_d;
    logic     step;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_EMPTY;
        else        state_q <= state_d;
    end

    // next state and per-cycle access outputs
    always_comb begin
        step   = 1'b0;
        wr_hit = 1'b0;
        rd_hit = 1'b0;
        unique case (op)
            OP_LOAD_WR:   begin step = 1'b1; wr_hit = 1'b1; end
            OP_LOAD_RD:   begin step = 1'b1; rd_hit = 1'b1; end
            OP_LOAD_BOTH: begin step = 1'b1; wr_hit = 1'b1; rd_hit = 1'b1; end
            default:      step = 1'b0;
        endcase
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SEL_EMPTY: state_d = SEL_FULL;
                SEL_FULL:  state_d = SEL_EMPTY;
            endcase
        end
    end

    assign sel = state_q;

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
    import ofs_seq_pkg::*;
#(
    parameter int unsigned OFS_W     = 16,
    parameter int unsigned RESET_OFS = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  ofs_sel_e         sel,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic [OFS_W-1:0] sel_ofs
);

    localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(RESET_OFS);

    logic [OFS_W-1:0] ofs_q [NUM_OFS];

    for (genvar i = 0; i < NUM_OFS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                ofs_q[i] <= RST_VAL;
            else if (wr_hit && (int'(sel) == i))
                ofs_q[i] <= wdata;
        end
    end

    assign ae_ofs  = ofs_q[int'(SEL_EMPTY)];
    assign af_ofs  = ofs_q[int'(SEL_FULL)];
    assign sel_ofs = (sel == SEL_FULL) ? af_ofs : ae_ofs;

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [OFS_W-1:0]  sel_ofs,
    output logic [DATA_W-1:0] dout
);

    localparam int unsigned PAD_W = DATA_W - OFS_W;

    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '0;
        else if (rd_hit) dout <= {{PAD_W{1'b0}}, sel_ofs};
    end

endmodule

// File: rtl/almost_ofs_seq.sv
module almost_ofs_seq
    import ofs_seq_pkg::*;
#(
    parameter int unsigned DATA_W    = 18,
    parameter int unsigned OFS_W     = 16,
    parameter int unsigned RESET_OFS = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic              fifo_wr_req,
    output logic              fifo_rd_req
);

    ofs_op_e          op;
    ofs_sel_e         sel_q;
    logic             wr_hit, rd_hit;
    logic [OFS_W-1:0] sel_ofs;

    ofs_op_decode u_dec (
        .load_n      (load_n),
        .wr_en_n     (wr_en_n),
        .rd_en_n     (rd_en_n),
        .op          (op),
        .fifo_wr_req (fifo_wr_req),
        .fifo_rd_req (fifo_rd_req)
    );

    ofs_sel_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .sel    (sel_q),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    ofs_bank #(.OFS_W(OFS_W), .RESET_OFS(RESET_OFS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .sel     (sel_q),
        .wdata   (din[OFS_W-1:0]),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .sel_ofs (sel_ofs)
    );

    ofs_readback #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hit  (rd_hit),
        .sel_ofs (sel_ofs),
        .dout    (dout)
    );

endmodule

// File: rtl/almost_ofs_seq_chk.sv
module almost_ofs_seq_chk
    import ofs_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic [OFS_W-1:0]  ae_ofs,
    input logic [OFS_W-1:0]  af_ofs,
    input ofs_sel_e          sel
);

    localparam int unsigned PAD_W = DATA_W - OFS_W;

    assert_write_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !wr_en_n && sel == SEL_EMPTY) |=>
            (ae_ofs == $past(din[OFS_W-1:0]) && $stable(af_ofs)));

    assert_write_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !wr_en_n && sel == SEL_FULL) |=>
            (af_ofs == $past(din[OFS_W-1:0]) && $stable(ae_ofs)));

    assert_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !(wr_en_n && rd_en_n)) |=> (sel != $past(sel)));

    assert_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && wr_en_n && rd_en_n) |=>
            ($stable(ae_ofs) && $stable(af_ofs) && $stable(sel) && $stable(dout)));

    assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(sel)));

    assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !rd_en_n) |=>
            (dout == {{PAD_W{1'b0}}, $past(sel == SEL_FULL ? af_ofs : ae_ofs)}));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!load_n && !rd_en_n) |=> $stable(dout));

endmodule

bind almost_ofs_seq almost_ofs_seq_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .wr_en_n (wr_en_n),
    .rd_en_n (rd_en_n),
    .din     (din),
    .dout    (dout),
    .ae_ofs  (ae_ofs),
    .af_ofs  (af_ofs),
    .sel     (sel_q)
);

// File: tb/almost_ofs_seq_tb.sv
module almost_ofs_seq_tb;

    localparam int DATA_W = 18;
    localparam int OFS_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_n = 1'b1, wr_en_n = 1'b1, rd_en_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic [OFS_W-1:0]  ae_ofs, af_ofs;
    logic              fifo_wr_req, fifo_rd_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [OFS_W-1:0]  m_ae, m_af;
    logic              m_sel;
    logic [DATA_W-1:0] m_dout;

    always #5 clk = ~clk;

    almost_ofs_seq u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
        .rd_en_n(rd_en_n), .din(din), .dout(dout), .ae_ofs(ae_ofs),
        .af_ofs(af_ofs), .fifo_wr_req(fifo_wr_req), .fifo_rd_req(fifo_rd_req)
    );

    function automatic logic [DATA_W-1:0] exp_rb(logic sel, logic [OFS_W-1:0] ae, logic [OFS_W-1:0] af);
        return {2'b00, (sel ? af : ae)};
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " ae"}, DATA_W'(ae_ofs), DATA_W'(m_ae));
        check({tag, " af"}, DATA_W'(af_ofs), DATA_W'(m_af));
        check({tag, " dout"}, dout, m_dout);
    endtask

    // one cycle: drive at negedge, check requests, update model, check after edge
    task automatic cyc(logic l, logic w, logic r, logic [DATA_W-1:0] d, string tag);
        logic [OFS_W-1:0]  old_sel_ofs;
        load_n = l; wr_en_n = w; rd_en_n = r; din = d;
        #1;
        check("R5 fifo_wr_req", DATA_W'(fifo_wr_req), DATA_W'(l & ~w));
        check("R5 fifo_rd_req", DATA_W'(fifo_rd_req), DATA_W'(l & ~r));
        old_sel_ofs = m_sel ? m_af : m_ae;
        if (!l && !(w && r)) begin
            if (!r) m_dout = {2'b00, old_sel_ofs};
            if (!w) begin
                if (m_sel) m_af = d[OFS_W-1:0];
                else       m_ae = d[OFS_W-1:0];
            end
            m_sel = ~m_sel;
        end
        @(posedge clk);
        #2;
        check_all(tag);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_ae = 16'd127; m_af = 16'd127; m_sel = 1'b0; m_dout = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R3: empty, full, empty with upper bits set (R2 truncation)
        cyc(0, 0, 1, 18'h3_1111, "R2 R3 first write empty");
        cyc(0, 0, 1, 18'h2_2222, "R2 R3 second write full");
        cyc(0, 0, 1, 18'h1_3333, "R3 third write empty");
        // R4: strobe low, no enables
        cyc(0, 1, 1, 18'h0_BEEF, "R4 nop");
        cyc(0, 1, 1, 18'h0_BEEF, "R4 nop again");
        // R6: selector at full; leave load, normal traffic, come back
        cyc(1, 0, 0, 18'h0_AAAA, "R5 pass both");
        cyc(1, 0, 1, 18'h0_AAAA, "R5 pass wr");
        cyc(1, 1, 0, 18'h0_AAAA, "R5 pass rd");
        cyc(0, 0, 1, 18'h0_4444, "R6 resume writes full");
        // R7 readback sequence: now at empty
        cyc(0, 1, 0, 18'h3_FFFF, "R7 readback empty");
        cyc(0, 1, 0, 18'h3_FFFF, "R7 readback full");
        cyc(1, 1, 1, 18'h0, "R8 hold idle");
        cyc(0, 0, 1, 18'h0_5555, "R8 hold on write");
        // R9: selector now full; simultaneous
        cyc(0, 0, 0, 18'h0_6666, "R9 both full");
        cyc(0, 1, 0, 18'h0, "R9 selector stepped once");

        for (int i = 0; i < 3000; i++) begin
            logic l, w, r;
            l = ($urandom_range(0, 3) == 0);
            w = $urandom_range(0, 1);
            r = $urandom_range(0, 1);
            cyc(l, w, r, DATA_W'($urandom), "R2/R3/R7/R8/R9 random");
        end

        // reset again mid-use
        rst_n = 1'b0;
        @(posedge clk); #2;
        m_ae = 16'd127; m_af = 16'd127; m_sel = 1'b0; m_dout = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 re-reset");
        cyc(0, 1, 0, 18'h0, "R1 selector back at empty");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule